// File: doc/BRIEF.md
# Single-Clock FIFO Write Port with Fill Thresholds

This block is the write side of a single-clock FIFO built on a small internal RAM. A word is stored on the rising clock edge when two active-low qualifiers, a write strobe and a block select, are both low. A word is not stored when the FIFO is already full. Each stored word carries one parity bit. That bit is either taken from the caller or computed inside the block, depending on a mode input.

Four status flags report the fill level: empty, full, fill level equal to a programmable threshold, and fill level at or above that threshold. The flags are recomputed on the falling edge of the same clock. A user that samples them on the next rising edge therefore sees the effect of the previous write. A parity-error output compares each qualified write's data against its supplied parity bit. A simple read port is included so that occupancy can be drained and observed. It works in first-word fall-through style.

Top module: `sfifo_wport`

## Requirements
- R1: On a rising edge, a word is stored only when `wr_n` and `sel_n` are both low. If either is high, nothing is stored.
- R2: While the FIFO holds 2**AW words (16 by default), a qualified write is dropped. The stored words and the write position stay unchanged, and the fill level never exceeds 2**AW.
- R3: `empty` (fill level 0) and `full` (fill level 2**AW) change only on the falling clock edge. They do not change at the rising edge that performed the write.
- R4: On the falling edge, `th_eq` is set to fill level == `thresh` and `th_ge` to fill level >= `thresh`. A change of `thresh` alone is reflected at the next falling edge.
- R5: `par_err` is a rising-edge register. After a qualified write with `pgen` low, it is 1 exactly when `wpar` differs from the XOR of all `wdata` bits. In every other case it is 0.
- R6: While `pgen` is high at a rising edge, `par_err` is 0 after that edge, whatever the data and parity.
- R7: The stored parity bit, returned on `rpar` with its word, is the XOR of the data bits when `pgen` was high at write time (even parity). Otherwise it is `wpar`.
- R8: `rdata`/`rpar` always show the oldest stored word. A rising edge with `rd` high and the FIFO not empty removes that word. A read together with a write leaves the fill level unchanged. A read while empty is ignored.
- R9: A synchronous active-high `rst` empties the FIFO and clears `par_err`. At the falling edge it sets `empty` to 1 and `full`, `th_eq` and `th_ge` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; data on rising edge, flags on falling edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| sel_n | input | 1 | Block select, active low |
| wdata | input | DW | Write data |
| wpar | input | 1 | Supplied parity bit for wdata |
| pgen | input | 1 | 1: compute parity internally, mask par_err |
| rd | input | 1 | Read/pop request |
| thresh | input | AW+1 | Fill-level threshold |
| rdata | output | DW | Oldest stored word |
| rpar | output | 1 | Parity bit stored with rdata |
| empty | output | 1 | Fill level is zero |
| full | output | 1 | Fill level is 2**AW |
| th_eq | output | 1 | Fill level equals thresh |
| th_ge | output | 1 | Fill level at or above thresh |
| par_err | output | 1 | Write parity mismatch |

## Verification
`par_err`, `rdata` and `rpar` are due one time unit after the rising edge that performs the write or read. The flags are due only after the following falling edge, half a cycle later. Each test task drives its inputs, reads `par_err` and the read port just after the rising edge, and reads the flags just after the next falling edge. For the first write the bench also reads `empty` right after the rising edge, to confirm that it has not moved yet. A threshold change is applied after a falling edge and checked after the next falling edge.

// File: rtl/sfifo_wport.sv
module sfifo_wport #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_n,
  input  logic          sel_n,
  input  logic [DW-1:0] wdata,
  input  logic          wpar,
  input  logic          pgen,
  input  logic          rd,
  input  logic [AW:0]   thresh,
  output logic [DW-1:0] rdata,
  output logic          rpar,
  output logic          empty,
  output logic          full,
  output logic          th_eq,
  output logic          th_ge,
  output logic          par_err
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] LEVEL_MAX = (AW+1)'(DEPTH);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   occ;

  wire strobe  = !wr_n && !sel_n;
  wire at_full = occ == LEVEL_MAX;
  wire do_wr   = strobe && !at_full;
  wire do_rd   = rd && (occ != '0);
  wire calc_p  = ^wdata;
  wire store_p = pgen ? calc_p : wpar;

  assign {rpar, rdata} = mem[rptr];

  always_ff @(posedge clk)
    if (do_wr && !rst) mem[wptr] <= {store_p, wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      occ     <= '0;
      par_err <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      par_err <= strobe && !pgen && (wpar != calc_p);
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      full  <= 1'b0;
      th_eq <= 1'b0;
      th_ge <= 1'b0;
    end else begin
      empty <= occ == '0;
      full  <= occ == LEVEL_MAX;
      th_eq <= occ == thresh;
      th_ge <= occ >= thresh;
    end
  end
endmodule

module sfifo_wport_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_n,
  input logic          sel_n,
  input logic          rd,
  input logic          pgen,
  input logic [AW:0]   thresh,
  input logic          empty,
  input logic          full,
  input logic          th_eq,
  input logic          th_ge,
  input logic          par_err,
  input logic [AW:0]   occ,
  input logic [AW-1:0] wptr
);
  localparam logic [AW:0] LEVEL_MAX = (AW+1)'(1 << AW);

  assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !sel_n && !full) |=> (occ != '0));

  assert_full_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (full && !rd) |=> ($stable(occ) && $stable(wptr)));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    occ <= LEVEL_MAX);

  assert_empty_flag_R3: assert property (@(posedge clk) disable iff (rst)
    empty == (occ == '0));

  assert_full_flag_R3: assert property (@(posedge clk) disable iff (rst)
    full == (occ == LEVEL_MAX));

  assert_eq_flag_R4: assert property (@(posedge clk) disable iff (rst)
    $stable(thresh) |-> (th_eq == (occ == thresh)));

  assert_eq_implies_ge_R4: assert property (@(posedge clk) disable iff (rst)
    th_eq |-> th_ge);

  assert_pgen_masks_R6: assert property (@(posedge clk) disable iff (rst)
    pgen |=> !par_err);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && rd && (wr_n || sel_n)) |=> $stable(occ));
endmodule

bind sfifo_wport sfifo_wport_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_n(wr_n), .sel_n(sel_n), .rd(rd), .pgen(pgen),
  .thresh(thresh), .empty(empty), .full(full), .th_eq(th_eq), .th_ge(th_ge),
  .par_err(par_err), .occ(occ), .wptr(wptr)
);

// File: tb/sim_sfifo_wport.sv
module sim_sfifo_wport;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1, sel_n = 1'b1, wpar = 1'b0, pgen = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [AW:0] thresh = 5'd5;
  logic [DW-1:0] rdata;
  logic rpar, empty, full, th_eq, th_ge, par_err;

  int checks = 0, fails = 0;
  logic [DW:0] mq[$];

  always #5 clk = ~clk;

  sfifo_wport #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .wr_n(wr_n), .sel_n(sel_n), .wdata(wdata), .wpar(wpar),
    .pgen(pgen), .rd(rd), .thresh(thresh), .rdata(rdata), .rpar(rpar),
    .empty(empty), .full(full), .th_eq(th_eq), .th_ge(th_ge), .par_err(par_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    int n = mq.size();
    check({req, " empty"}, 32'(empty), 32'(n == 0));
    check({req, " full"},  32'(full),  32'(n == DEPTH));
    check({req, " th_eq"}, 32'(th_eq), 32'(n == int'(thresh)));
    check({req, " th_ge"}, 32'(th_ge), 32'(n >= int'(thresh)));
  endtask

  // one cycle: drive just after a falling edge, check par_err/read port after rise, flags after fall
  task automatic op(input logic w, input logic r, input logic [DW-1:0] d, input logic p);
    logic rd_ok, wr_ok, exp_err;
    rd_ok = r && mq.size() > 0;
    wr_ok = w && mq.size() < DEPTH;
    if (rd_ok) begin
      check("R8 rdata", 32'(rdata), 32'(mq[0][DW-1:0]));
      check("R7 rpar", 32'(rpar), 32'(mq[0][DW]));
    end
    exp_err = w && !pgen && (p != ^d);
    wr_n = !w; sel_n = !w; rd = r; wdata = d; wpar = p;
    @(posedge clk); #1;
    wr_n = 1'b1; sel_n = 1'b1; rd = 1'b0;
    if (rd_ok) void'(mq.pop_front());
    if (wr_ok) mq.push_back({pgen ? ^d : p, d});
    check(pgen ? "R6 par_err" : "R5 par_err", 32'(par_err), 32'(exp_err));
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    check_flags("R9 after reset");
    check("R9 par_err", 32'(par_err), 0);
  endtask

  task automatic t_qualifiers();
    wr_n = 1'b0; sel_n = 1'b1; wdata = 8'h11;
    @(posedge clk); #1; @(negedge clk); #1;
    check("R1 sel_n high blocks", 32'(empty), 1);
    wr_n = 1'b1; sel_n = 1'b0;
    @(posedge clk); #1; @(negedge clk); #1;
    check("R1 wr_n high blocks", 32'(empty), 1);
    sel_n = 1'b1;
  endtask

  task automatic t_fill();
    thresh = 5'd5;
    wr_n = 1'b0; sel_n = 1'b0; wdata = 8'h03; wpar = ^8'h03;
    @(posedge clk); #1;
    check("R3 empty holds at rising edge", 32'(empty), 1);
    wr_n = 1'b1; sel_n = 1'b1;
    mq.push_back({1'b0, 8'h03});
    @(negedge clk); #1;
    check_flags("R3 first write");
    for (int i = 1; i < DEPTH; i++) begin
      op(1'b1, 1'b0, 8'(i * 7 + 3), ^8'(i * 7 + 3));
      check_flags("R4 fill");
    end
  endtask

  task automatic t_full_drain();
    op(1'b1, 1'b0, 8'hEE, ^8'hEE);
    check_flags("R2 write while full");
    for (int i = 0; i < DEPTH; i++) begin
      op(1'b0, 1'b1, '0, 1'b0);
      check_flags("R8 drain");
    end
  endtask

  task automatic t_thresh();
    for (int i = 0; i < 3; i++) op(1'b1, 1'b0, 8'(8'h40 + i), ^8'(8'h40 + i));
    thresh = 5'd3; @(negedge clk); #1; check_flags("R4 thresh=3");
    thresh = 5'd4; @(negedge clk); #1; check_flags("R4 thresh=4");
    thresh = 5'd2; @(negedge clk); #1; check_flags("R4 thresh=2");
    thresh = 5'd3; @(negedge clk); #1;
  endtask

  task automatic t_rw();
    for (int i = 0; i < 4; i++) begin
      op(1'b1, 1'b1, 8'(8'h80 + i), ^8'(8'h80 + i));
      check_flags("R8 read+write");
    end
    while (mq.size() > 0) op(1'b0, 1'b1, '0, 1'b0);
  endtask

  task automatic t_empty_read();
    op(1'b0, 1'b1, '0, 1'b0);
    check_flags("R8 read while empty");
    op(1'b1, 1'b0, 8'h5A, ^8'h5A);
    check("R8 rdata after empty read", 32'(rdata), 32'h5A);
    op(1'b0, 1'b1, '0, 1'b0);
  endtask

  task automatic t_parity();
    pgen = 1'b0;
    op(1'b1, 1'b0, 8'h07, 1'b0);
    op(1'b1, 1'b0, 8'h07, 1'b1);
    pgen = 1'b1;
    op(1'b1, 1'b0, 8'h0B, 1'b0);
    op(1'b1, 1'b0, 8'h0C, 1'b1);
    pgen = 1'b0;
    for (int i = 0; i < 4; i++) op(1'b0, 1'b1, '0, 1'b0);
    check_flags("R7 after drain");
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 7; i++) op(1'b1, 1'b0, 8'(i), 1'b1);
    rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    mq.delete();
    @(negedge clk); #1;
    check_flags("R9 reset mid-fill");
    check("R9 par_err mid", 32'(par_err), 0);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_qualifiers();
    t_fill();
    t_full_drain();
    t_thresh();
    t_rw();
    t_empty_read();
    t_parity();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule